// File: doc/BRIEF.md
# NAND Page Data Randomizer

This block scrambles the byte stream between a flash controller's data path and the flash pins, so that long runs of equal bits never reach the memory cells. Each byte is XORed with a key byte drawn from a 15-bit linear feedback shift register. The XOR is its own inverse, so the same logic scrambles bytes on their way to the flash and restores them on the way back.

At the start of every chunk transfer the controller pulses `start` together with the page number, the pages-per-block count and a mode flag. The block looks up a seed from one of three loadable seed sets and loads it into the register. The sets are one for plain page data and one each for ECC-protected spare bytes with small or large chunks. Bytes then flow through a valid/ready stream; the keystream moves only when a byte is actually accepted. A separate combinational helper scrambles or restores the two bad-block-marker bytes with the spare-set seed of the current page. Seed contents come in through a write port, so no table is fixed in logic.

Top module: `page_scrambler`

## Requirements
- R1: The generator state is 15 bits wide and seeds are 15-bit values. After reset the state and every seed entry are zero, so the key is 0x00 and data and marker bytes pass unchanged.
- R2: One LFSR step shifts the state right by one bit and places bit0 XOR bit1 in bit 14. The key for a byte is state bits 7..0, and after each accepted byte the state advances by 8 steps.
- R3: The seed slot is page modulo M. M is `pages_per_block`, except that M is 128 (the table depth) when `pages_per_block` is 0 or greater than 128.
- R4: With `spare_mode` low the data set (set code 0) seeds the stream. With it high, `chunk_large` picks set code 2 (1024-byte chunks) over set code 1 (512-byte chunks).
- R5: A `start` pulse loads the selected seed, also in the middle of a chunk. In the start cycle `in_ready` and `out_valid` are low, so no byte moves.
- R6: A cycle without a transfer (`in_valid` and `in_ready` not both high) leaves the keystream unchanged. `in_ready` follows `out_ready` outside start cycles.
- R7: With `enable` low, `out_data` equals `in_data` and accepted bytes do not advance the state. With `enable` low, `mark_out` equals `mark_in`.
- R8: With `enable` high, `mark_out[7:0]` is `mark_in[7:0]` XOR the low byte of the spare-set seed (set chosen by `chunk_large`, slot from R3). `mark_out[15:8]` is `mark_in[15:8]` XOR the low byte of that seed advanced 8 steps. This holds whatever the value of `spare_mode`.
- R9: Scrambling a buffer and then scrambling the result again with the same page and mode returns the original bytes.
- R10: A seed write stores `seed_val` at `seed_idx` of set `seed_set` (0 data, 1 small-chunk spare, 2 large-chunk spare). Set code 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Scrambling on; low gives pass-through |
| start | input | 1 | Reload the seed for a new chunk |
| page | input | PAGE_W | Page number |
| pages_per_block | input | PPB_W | Pages in one erase block |
| spare_mode | input | 1 | Stream carries ECC-protected spare bytes |
| chunk_large | input | 1 | ECC chunk is 1024 bytes (else 512) |
| seed_we | input | 1 | Seed write strobe |
| seed_set | input | 2 | Seed set code for the write |
| seed_idx | input | IDX_W | Seed slot for the write |
| seed_val | input | 15 | Seed value to write |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 8 | Scrambled byte |
| mark_in | input | 16 | Two marker bytes, byte 0 in bits 7..0 |
| mark_out | output | 16 | Scrambled marker bytes |

## Verification
The hardest case to reach is a keystream that must stay frozen while a byte sits offered for several cycles with the consumer not ready, then continue exactly where it stopped. The same applies to bytes that pass while `enable` is low in the middle of a chunk. The bench holds `out_ready` low for several cycles with a byte presented, then toggles `enable` around individual bytes. Its scoreboard model advances only on accepted scrambled bytes, so any extra or missing step shows up on every byte that follows. A restart in the middle of a chunk and a write to the unused set code are also driven, and both are judged by the bytes that follow them.

// File: rtl/pscr_pkg.sv
package pscr_pkg;
  localparam int unsigned LFSR_W   = 15;
  localparam int unsigned NUM_SETS = 3;

  typedef logic [LFSR_W-1:0] lfsr_t;

  typedef enum logic [1:0] {
    SET_DATA        = 2'd0,
    SET_SPARE_SMALL = 2'd1,
    SET_SPARE_LARGE = 2'd2,
    SET_VOID        = 2'd3
  } seed_set_e;

  // single shift: feedback of the two lowest bits enters at the top
  function automatic lfsr_t lfsr_step(input lfsr_t s);
    return {s[0] ^ s[1], s[LFSR_W-1:1]};
  endfunction

  // eight steps, one key byte worth
  function automatic lfsr_t lfsr_byte_adv(input lfsr_t s);
    lfsr_t t;
    t = s;
    for (int k = 0; k < 8; k++) t = lfsr_step(t);
    return t;
  endfunction

  function automatic logic [7:0] lfsr_key(input lfsr_t s);
    return s[7:0];
  endfunction

  // slot = page mod M, M capped at the table depth (0 also means the cap)
  function automatic int unsigned seed_slot(input int unsigned page,
                                            input int unsigned ppb,
                                            input int unsigned nseeds);
    int unsigned m;
    m = (ppb == 0 || ppb > nseeds) ? nseeds : ppb;
    return page % m;
  endfunction
endpackage

// File: rtl/pscr_seed_table.sv
module pscr_seed_table
  import pscr_pkg::*;
#(
  parameter int unsigned NUM_SEEDS = 128,
  parameter int unsigned PAGE_W    = 16,
  parameter int unsigned PPB_W     = 9,
  localparam int unsigned IDX_W    = $clog2(NUM_SEEDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_set,
  input  logic [IDX_W-1:0]  wr_idx,
  input  lfsr_t             wr_seed,
  input  logic [PAGE_W-1:0] page,
  input  logic [PPB_W-1:0]  ppb,
  input  logic              spare_mode,
  input  logic              chunk_large,
  output lfsr_t             stream_seed,
  output lfsr_t             spare_seed
);
  lfsr_t            mem [NUM_SETS][NUM_SEEDS];
  logic [IDX_W-1:0] slot;
  logic [1:0]       spare_set;
  lfsr_t            data_seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int i = 0; i < NUM_SEEDS; i++) mem[s][i] <= '0;
    end else if (wr_en && wr_set != SET_VOID) begin
      mem[wr_set][wr_idx] <= wr_seed;
    end
  end

  assign slot        = IDX_W'(seed_slot(32'(page), 32'(ppb), NUM_SEEDS));
  assign spare_set   = chunk_large ? SET_SPARE_LARGE : SET_SPARE_SMALL;
  assign spare_seed  = mem[spare_set][slot];
  assign data_seed   = mem[SET_DATA][slot];
  assign stream_seed = spare_mode ? spare_seed : data_seed;

  AST_VOID_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && wr_set == SET_VOID) && $stable(page) && $stable(ppb) &&
     $stable(spare_mode) && $stable(chunk_large))
    |-> ($stable(stream_seed) && $stable(spare_seed))); // R10
endmodule

// File: rtl/pscr_keystream.sv
module pscr_keystream
  import pscr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  lfsr_t      seed,
  input  logic       advance,
  output logic [7:0] key
);
  lfsr_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= '0;
    else if (load)    state <= seed;
    else if (advance) state <= lfsr_byte_adv(state);
  end

  assign key = lfsr_key(state);

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(state)); // R6
  AST_RELOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state == $past(seed))); // R5
endmodule

// File: rtl/pscr_marker.sv
module pscr_marker
  import pscr_pkg::*;
(
  input  logic        enable,
  input  lfsr_t       seed,
  input  logic [15:0] mark_in,
  output logic [15:0] mark_out
);
  logic [7:0] key_lo;
  logic [7:0] key_hi;

  assign key_lo   = lfsr_key(seed);
  assign key_hi   = lfsr_key(lfsr_byte_adv(seed));
  assign mark_out = enable ? {mark_in[15:8] ^ key_hi, mark_in[7:0] ^ key_lo}
                           : mark_in;
endmodule

// File: rtl/page_scrambler.sv
module page_scrambler
  import pscr_pkg::*;
#(
  parameter int unsigned NUM_SEEDS = 128,
  parameter int unsigned PAGE_W    = 16,
  parameter int unsigned PPB_W     = 9,
  localparam int unsigned IDX_W    = $clog2(NUM_SEEDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic [PAGE_W-1:0] page,
  input  logic [PPB_W-1:0]  pages_per_block,
  input  logic              spare_mode,
  input  logic              chunk_large,
  input  logic              seed_we,
  input  logic [1:0]        seed_set,
  input  logic [IDX_W-1:0]  seed_idx,
  input  logic [LFSR_W-1:0] seed_val,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  input  logic [15:0]       mark_in,
  output logic [15:0]       mark_out
);
  lfsr_t      stream_seed;
  lfsr_t      spare_seed;
  logic [7:0] key;
  logic       xfer;
  logic       advance;

  pscr_seed_table #(
    .NUM_SEEDS(NUM_SEEDS), .PAGE_W(PAGE_W), .PPB_W(PPB_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(seed_we), .wr_set(seed_set), .wr_idx(seed_idx), .wr_seed(seed_val),
    .page(page), .ppb(pages_per_block),
    .spare_mode(spare_mode), .chunk_large(chunk_large),
    .stream_seed(stream_seed), .spare_seed(spare_seed)
  );

  // stream handshake: a start cycle moves no byte
  assign in_ready  = out_ready && !start;
  assign out_valid = in_valid && !start;
  assign xfer      = in_valid && in_ready;
  assign advance   = xfer && enable;

  pscr_keystream u_keys (
    .clk(clk), .rst_n(rst_n),
    .load(start), .seed(stream_seed), .advance(advance), .key(key)
  );

  assign out_data = enable ? (in_data ^ key) : in_data;

  pscr_marker u_mark (
    .enable(enable), .seed(spare_seed), .mark_in(mark_in), .mark_out(mark_out)
  );

  AST_START_BLOCKS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!in_ready && !out_valid)); // R5
  AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (out_data == in_data)); // R7
  AST_BYPASS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (mark_out == mark_in)); // R7
endmodule

// File: tb/page_scrambler_bench.sv
module page_scrambler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1, start = 1'b0;
  logic [15:0] page = '0;
  logic [8:0]  ppb = '0;
  logic        spare_mode = 1'b0, chunk_large = 1'b0;
  logic        seed_we = 1'b0;
  logic [1:0]  seed_set = '0;
  logic [6:0]  seed_idx = '0;
  logic [14:0] seed_val = '0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid;
  logic [7:0]  out_data;
  logic [15:0] mark_in = '0, mark_out;

  always #5 clk = ~clk;

  page_scrambler u_page_scrambler (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .page(page),
    .pages_per_block(ppb), .spare_mode(spare_mode), .chunk_large(chunk_large),
    .seed_we(seed_we), .seed_set(seed_set), .seed_idx(seed_idx), .seed_val(seed_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mark_in(mark_in), .mark_out(mark_out)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R2";
  logic [14:0] tb_data [128];
  logic [14:0] tb_s512 [128];
  logic [14:0] tb_s1k  [128];
  logic [7:0]  exp_q [$];
  logic [7:0]  seen [$];
  logic [7:0]  orig [8];
  logic [14:0] m_st;

  // model: shift right, new top bit from the two lowest bits
  function automatic logic [14:0] m_step(input logic [14:0] s);
    logic [15:0] w;
    w = {1'b0, s};
    w = (w >> 1) | (((w ^ (w >> 1)) & 16'd1) << 14);
    return w[14:0];
  endfunction
  function automatic logic [14:0] m_adv(input logic [14:0] s, input int n);
    logic [14:0] t;
    t = s;
    for (int i = 0; i < n; i++) t = m_step(t);
    return t;
  endfunction
  function automatic int m_slot(input int pg, input int pb);
    int m;
    m = (pb < 1 || pb > 128) ? 128 : pb;
    return pg % m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected bytes as the design hands them out
  initial forever begin
    @(negedge clk);
    #3;
    if (rst_n && out_valid && out_ready) begin
      logic [7:0] e;
      seen.push_back(out_data);
      if (exp_q.size() == 0) chk(1'b0, {cur_req, " unexpected byte"}, {24'd0, out_data}, 32'd0);
      else begin
        e = exp_q.pop_front();
        chk(out_data === e, cur_req, {24'd0, out_data}, {24'd0, e});
      end
    end
  end

  task automatic send(input logic [7:0] b, input logic en);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; enable = en;
    if (en) begin
      exp_q.push_back(b ^ m_st[7:0]);
      m_st = m_adv(m_st, 8);
    end else exp_q.push_back(b);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0; enable = 1'b1;
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, {cur_req, " queue drained"}, exp_q.size(), 0);
  endtask

  task automatic begin_chunk(input int pg, input int pb, input logic sp, input logic lg);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h77; enable = 1'b1;
    page = 16'(pg); ppb = 9'(pb); spare_mode = sp; chunk_large = lg; start = 1'b1;
    #3;
    chk(!in_ready && !out_valid, "R5 start cycle moves no byte", {30'd0, in_ready, out_valid}, 0);
    if (!sp) m_st = tb_data[m_slot(pg, pb)];
    else if (lg) m_st = tb_s1k[m_slot(pg, pb)];
    else m_st = tb_s512[m_slot(pg, pb)];
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
  endtask

  task automatic write_seed(input logic [1:0] st, input int idx, input logic [14:0] v);
    @(negedge clk);
    seed_we = 1'b1; seed_set = st; seed_idx = 7'(idx); seed_val = v;
    @(negedge clk);
    seed_we = 1'b0;
  endtask

  task automatic mark_check(input int pg, input int pb, input logic lg, input logic sp, input string req);
    logic [14:0] s;
    logic [14:0] s8;
    logic [15:0] e;
    @(negedge clk);
    page = 16'(pg); ppb = 9'(pb); chunk_large = lg; spare_mode = sp; enable = 1'b1; mark_in = 16'hA55A;
    s  = lg ? tb_s1k[m_slot(pg, pb)] : tb_s512[m_slot(pg, pb)];
    s8 = m_adv(s, 8);
    e  = {mark_in[15:8] ^ s8[7:0], mark_in[7:0] ^ s[7:0]};
    #3;
    chk(mark_out === e, req, {16'd0, mark_out}, {16'd0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      logic [15:0] raw;
      raw = 16'(i * 40503 + 777);
      tb_data[i] = raw[14:0];
      tb_s512[i] = m_adv(tb_data[i], 512 * 8 + 15);
      tb_s1k[i]  = m_adv(tb_data[i], 1024 * 8 + 15);
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state gives a zero key and untouched markers
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h5A; mark_in = 16'h1234;
    #3;
    chk(out_data === 8'h5A, "R1 reset key is zero", {24'd0, out_data}, 32'h5A);
    chk(mark_out === 16'h1234, "R1 reset marker unchanged", {16'd0, mark_out}, 32'h1234);
    chk(in_ready === 1'b0, "R6 ready follows out_ready", {31'd0, in_ready}, 0);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;

    // R10: load the three sets
    for (int i = 0; i < 128; i++) write_seed(2'd0, i, tb_data[i]);
    for (int i = 0; i < 128; i++) write_seed(2'd1, i, tb_s512[i]);
    for (int i = 0; i < 128; i++) write_seed(2'd2, i, tb_s1k[i]);

    // R2 R3: data mode, slot = 200 mod 64 = 8
    cur_req = "R2 data keystream page 200 ppb 64";
    begin_chunk(200, 64, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) send(8'(i * 37 + 1), 1'b1);
    drain();

    cur_req = "R3 ppb 0 uses 128 (slot 44)";
    begin_chunk(300, 0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) send(8'hFF, 1'b1);
    drain();
    cur_req = "R3 ppb 256 capped (slot 2)";
    begin_chunk(130, 256, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) send(8'h00, 1'b1);
    drain();
    cur_req = "R3 ppb 128 slot 127";
    begin_chunk(127, 128, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) send(8'h3C, 1'b1);
    drain();

    // R4: spare sets
    cur_req = "R4 spare 512 set";
    begin_chunk(10, 64, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) send(8'(i + 8'h10), 1'b1);
    drain();
    cur_req = "R4 spare 1024 set";
    begin_chunk(10, 64, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) send(8'(i + 8'h10), 1'b1);
    drain();

    // R5: restart mid chunk
    cur_req = "R5 mid-chunk restart";
    begin_chunk(33, 32, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) send(8'hA0, 1'b1);
    begin_chunk(33, 32, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) send(8'hA0, 1'b1);
    drain();

    // R6: stall holds the keystream
    cur_req = "R6 stall does not advance";
    begin_chunk(5, 16, 1'b0, 1'b0);
    send(8'h11, 1'b1);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'hC3;
    repeat (3) begin
      #3;
      chk(in_ready === 1'b0, "R6 no accept while out_ready low", {31'd0, in_ready}, 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    exp_q.push_back(8'hC3 ^ m_st[7:0]);
    m_st = m_adv(m_st, 8);
    send(8'h22, 1'b1);
    drain();

    // R7: bypass in mid chunk keeps the state
    cur_req = "R7 disable passes bytes and holds state";
    begin_chunk(9, 64, 1'b0, 1'b0);
    send(8'h01, 1'b1);
    send(8'h02, 1'b1);
    send(8'h5A, 1'b0);
    send(8'hA5, 1'b0);
    send(8'h03, 1'b1);
    send(8'h04, 1'b1);
    drain();
    @(negedge clk);
    enable = 1'b0; mark_in = 16'hBEEF; page = 16'd3; ppb = 9'd64; chunk_large = 1'b0;
    #3;
    chk(mark_out === 16'hBEEF, "R7 marker bypass when disabled", {16'd0, mark_out}, 32'hBEEF);
    @(negedge clk);
    enable = 1'b1;

    // R8: marker helper
    mark_check(3, 64, 1'b0, 1'b0, "R8 marker 512 set");
    mark_check(70, 0, 1'b1, 1'b0, "R8 marker 1024 set");
    mark_check(70, 0, 1'b1, 1'b1, "R8 marker independent of spare_mode");

    // R9: scramble twice restores
    cur_req = "R9 first pass";
    seen.delete();
    begin_chunk(77, 64, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      orig[i] = 8'(i * 29 + 5);
      send(orig[i], 1'b1);
    end
    drain();
    cur_req = "R9 second pass";
    begin_chunk(77, 64, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) send(seen[i], 1'b1);
    drain();
    for (int i = 0; i < 8; i++)
      chk(seen[8 + i] === orig[i], "R9 round trip restores byte", {24'd0, seen[8 + i]}, {24'd0, orig[i]});

    // R10: set code 3 stores nothing
    write_seed(2'd3, 8, 15'h7FFF);
    cur_req = "R10 void set write inert";
    begin_chunk(200, 64, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) send(8'h99, 1'b1);
    drain();
    mark_check(8, 64, 1'b0, 1'b0, "R10 spare set untouched by void write");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule